// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block is a bus-attached parallel I/O peripheral. A host processor reaches it through a small synchronous interface made of an active-low select, active-low read and write strobes, a 2-bit register address and an 8-bit data bus. Behind that interface sit three 8-bit pin groups, named A, B and C, and one control register. Groups A and B each have a single direction setting. Group C is split into an upper and a lower nibble, and each nibble has its own direction.

Each pin group has separate output-value, output-enable and input-value signals, so the block never models a tristate pad. An output group holds the last value written to it in a latch, and that value stays on the pins after the bus cycle ends. An input group is not captured: a read returns whatever is on the pins during that read. The control register takes two kinds of command word, selected by bit 7. A word with bit 7 high redefines the direction of every group and clears all output latches. A word with bit 7 low sets or clears a single line of group C.

A write takes effect at the rising clock edge where select and write strobe are both low. Read data is combinational and depends on address and pin state while select and read strobe are low.

Top module: `pio_ctrl`

## Requirements
- R1: After reset every group is an input, every output enable is 0 and every output latch is 0.
- R2: While bus_cs_n is 1, writes change nothing and bus_rdata is 0.
- R3: A control word with bit 7 = 1 and bits 6:5 = 00 and bit 2 = 0 sets the directions, with 1 meaning input: bit 4 for group A, bit 3 for group C upper nibble, bit 1 for group B, bit 0 for group C lower nibble. The same write clears all three output latches to 0.
- R4: A control word with bit 7 = 1 and a nonzero value in bits 6:5 or bit 2 leaves directions and latches unchanged.
- R5: Writing address 00, 01 or 10 loads the latch of group A, B or C. The latch drives the group's output pins and keeps its value until the next write to it.
- R6: The output enables of a group or nibble are all 1 when it is an output and all 0 when it is an input. A C nibble configured as input never drives.
- R7: A control word with bit 7 = 0 writes bit 0 into the group C latch line selected by bits 3:1. The other seven C latch bits keep their values.
- R8: A read of address 00, 01 or 10 returns the live pins of an input group or nibble and the latch of an output group or nibble. Group C is handled nibble by nibble.
- R9: A read of address 11 returns 0. bus_rdata is 0 whenever no read is active.
- R10: After a group switches from output to input, its enables drop and reads return its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Active-low select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when idle |
| pa_in | input | 8 | Group A pin values |
| pa_out | output | 8 | Group A output values |
| pa_oe | output | 8 | Group A output enables |
| pb_in | input | 8 | Group B pin values |
| pb_out | output | 8 | Group B output values |
| pb_oe | output | 8 | Group B output enables |
| pc_in | input | 8 | Group C pin values |
| pc_out | output | 8 | Group C output values |
| pc_oe | output | 8 | Group C output enables |

## Verification
The bench builds the block with its default 8-bit data path. At that width all 16 direction combinations fit in one sweep. For each combination it drives fresh pin patterns, writes the latches and compares every enable, output and readback against a model kept in the bench. The small width also allows every C line to be set and cleared with both values. The remaining cases are the rejected control words, writes while deselected, and the change from output to input.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int DW     = 8;
    localparam int NIB_W  = DW / 2;
    localparam int LINE_W = $clog2(DW);

    localparam logic [1:0] ADR_A   = 2'd0;
    localparam logic [1:0] ADR_B   = 2'd1;
    localparam logic [1:0] ADR_C   = 2'd2;
    localparam logic [1:0] ADR_CTL = 2'd3;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;

    typedef struct packed {
        dir_t          dir;
        logic [DW-1:0] lat_a;
        logic [DW-1:0] lat_b;
        logic [DW-1:0] lat_c;
    } pio_state_t;
endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
    import pio_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic       wr_a,
    output logic       wr_b,
    output logic       wr_c,
    output logic       wr_ctl,
    output logic       rd_en
);
    logic wr_en;

    always_comb begin
        wr_en  = !cs_n && !wr_n;
        rd_en  = !cs_n && !rd_n;
        wr_a   = wr_en && (addr == ADR_A);
        wr_b   = wr_en && (addr == ADR_B);
        wr_c   = wr_en && (addr == ADR_C);
        wr_ctl = wr_en && (addr == ADR_CTL);
    end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic          wr_c,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output pio_state_t    st
);
    pio_state_t st_d, st_q;
    logic       mode_ok_d;
    logic       mode_bad_d;
    logic       bsr_d;
    logic [DW-1:0] line_mask_d;

    always_comb begin
        st_d        = st_q;
        mode_ok_d   = wr_ctl && wdata[7] && (wdata[6:5] == 2'b00) && !wdata[2];
        mode_bad_d  = wr_ctl && wdata[7] && ((wdata[6:5] != 2'b00) || wdata[2]);
        bsr_d       = wr_ctl && !wdata[7];
        line_mask_d = {{(DW-1){1'b0}}, 1'b1} << wdata[3:1];

        if (wr_a) st_d.lat_a = wdata;
        if (wr_b) st_d.lat_b = wdata;
        if (wr_c) st_d.lat_c = wdata;

        if (mode_ok_d) begin
            st_d.dir.a_in  = wdata[4];
            st_d.dir.cu_in = wdata[3];
            st_d.dir.b_in  = wdata[1];
            st_d.dir.cl_in = wdata[0];
            st_d.lat_a     = '0;
            st_d.lat_b     = '0;
            st_d.lat_c     = '0;
        end else if (bsr_d) begin
            st_d.lat_c = wdata[0] ? (st_q.lat_c | line_mask_d)
                                  : (st_q.lat_c & ~line_mask_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dir   <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
            st_q.lat_a <= '0;
            st_q.lat_b <= '0;
            st_q.lat_c <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R3
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok_d |=> (st_q.lat_a == '0 && st_q.lat_b == '0 && st_q.lat_c == '0));

    // R4
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bad_d |=> $stable(st_q));

    // R7
    bsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_d |=> (((st_q.lat_c ^ $past(st_q.lat_c)) & ~$past(line_mask_d)) == '0)
                  && ((st_q.lat_c & $past(line_mask_d)) ==
                      ($past(wdata[0]) ? $past(line_mask_d) : '0)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_a || wr_b || wr_c || wr_ctl) |=> $stable(st_q));
endmodule

// File: rtl/pio_pins.sv
module pio_pins
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  pio_state_t    st,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] a_view, b_view, c_view;
    logic [1:0]    c_half_in;

    assign c_half_in = {st.dir.cu_in, st.dir.cl_in};

    always_comb begin
        pa_out = st.lat_a;
        pb_out = st.lat_b;
        pc_out = st.lat_c;
        pa_oe  = {DW{!st.dir.a_in}};
        pb_oe  = {DW{!st.dir.b_in}};
        a_view = st.dir.a_in ? pa_in : st.lat_a;
        b_view = st.dir.b_in ? pb_in : st.lat_b;
    end

    for (genvar h = 0; h < 2; h++) begin : g_c_half
        assign pc_oe[h*NIB_W +: NIB_W]  = {NIB_W{!c_half_in[h]}};
        assign c_view[h*NIB_W +: NIB_W] = c_half_in[h] ? pc_in[h*NIB_W +: NIB_W]
                                                       : st.lat_c[h*NIB_W +: NIB_W];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADR_A:   rdata = a_view;
                ADR_B:   rdata = b_view;
                ADR_C:   rdata = c_view;
                default: rdata = '0;
            endcase
        end
    end

    // R6
    cu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.dir.cu_in |-> (pc_oe[DW-1:NIB_W] == '0));

    // R6
    cl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.dir.cl_in |-> (pc_oe[NIB_W-1:0] == '0));

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_rd_n,
    input  logic          bus_wr_n,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic       wr_a, wr_b, wr_c, wr_ctl, rd_en;
    pio_state_t st;

    pio_bus_if u_bus (
        .cs_n   (bus_cs_n),
        .rd_n   (bus_rd_n),
        .wr_n   (bus_wr_n),
        .addr   (bus_addr),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .wr_c   (wr_c),
        .wr_ctl (wr_ctl),
        .rd_en  (rd_en)
    );

    pio_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .wr_c   (wr_c),
        .wr_ctl (wr_ctl),
        .wdata  (bus_wdata),
        .st     (st)
    );

    pio_pins u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .st     (st),
        .rd_en  (rd_en),
        .addr   (bus_addr),
        .pa_in  (pa_in),
        .pb_in  (pb_in),
        .pc_in  (pc_in),
        .pa_out (pa_out),
        .pa_oe  (pa_oe),
        .pb_out (pb_out),
        .pb_oe  (pb_oe),
        .pc_out (pc_out),
        .pc_oe  (pc_oe),
        .rdata  (bus_rdata)
    );

    // R2
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_rdata == '0));
endmodule

// File: tb/pio_ctrl_bench.sv
module pio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'd0, pb_in = 8'd0, pc_in = 8'd0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;

    logic m_a_in, m_b_in, m_cu_in, m_cl_in;
    logic [7:0] m_la, m_lb, m_lc;

    always #5 clk = ~clk;

    pio_ctrl u_pio_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_la = d;
            2'd1: m_lb = d;
            2'd2: m_lc = d;
            default: begin
                if (d[7]) begin
                    if (d[6:5] == 2'b00 && !d[2]) begin
                        m_a_in = d[4]; m_cu_in = d[3]; m_b_in = d[1]; m_cl_in = d[0];
                        m_la = 8'd0; m_lb = 8'd0; m_lc = 8'd0;
                    end
                end else begin
                    m_lc[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_a_in ? pa_in : m_la;
            2'd1: return m_b_in ? pb_in : m_lb;
            2'd2: return {m_cu_in ? pc_in[7:4] : m_lc[7:4], m_cl_in ? pc_in[3:0] : m_lc[3:0]};
            default: return 8'd0;
        endcase
    endfunction

    task automatic check_pins(input string tag);
        check({tag, " pa_oe"}, pa_oe, {8{!m_a_in}});
        check({tag, " pb_oe"}, pb_oe, {8{!m_b_in}});
        check({tag, " pc_oe"}, pc_oe, {{4{!m_cu_in}}, {4{!m_cl_in}}});
        check({tag, " pa_out"}, pa_out, m_la);
        check({tag, " pb_out"}, pb_out, m_lb);
        check({tag, " pc_out"}, pc_out, m_lc);
    endtask

    task automatic check_reads(input string tag);
        for (int a = 0; a < 4; a++) begin
            logic [7:0] r;
            bus_read(a[1:0], r);
            check($sformatf("%s read addr %0d", tag, a), r, exp_read(a[1:0]));
        end
    endtask

    function automatic logic [7:0] mode_word(input logic [3:0] m);
        return {1'b1, 2'b00, m[3], m[2], 1'b0, m[1], m[0]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        m_a_in = 1; m_b_in = 1; m_cu_in = 1; m_cl_in = 1;
        m_la = 0; m_lb = 0; m_lc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_pins("R1 reset");
        check("R9 idle rdata", rdata, 8'd0);

        // R3 R5 R6 R8 R9: sweep every direction combination
        for (int m = 0; m < 16; m++) begin
            bus_write(2'd3, mode_word(m[3:0]));
            check_pins($sformatf("R3 after mode %0d", m));
            bus_write(2'd0, 8'(m * 37 + 5));
            bus_write(2'd1, 8'(m * 53 + 9) ^ 8'hA5);
            bus_write(2'd2, 8'(m * 71 + 3));
            pa_in = 8'(m * 29) ^ 8'h3C;
            pb_in = 8'(m * 17) ^ 8'hC3;
            pc_in = 8'(m * 13) ^ 8'h96;
            repeat (2) @(negedge clk);
            #1;
            check_pins($sformatf("R5 R6 latch hold mode %0d", m));
            check_reads($sformatf("R8 R9 mode %0d", m));
        end

        // R7: every line, both values, C all output
        bus_write(2'd3, mode_word(4'b0000));
        bus_write(2'd2, 8'h5A);
        for (int ln = 0; ln < 8; ln++) begin
            for (int v = 0; v < 2; v++) begin
                bus_write(2'd3, {4'b0000, ln[2:0], v[0]});
                check($sformatf("R7 line %0d val %0d", ln, v), pc_out, m_lc);
            end
        end

        // R4: rejected control words
        bus_write(2'd3, mode_word(4'b1010));
        bus_write(2'd0, 8'h77); bus_write(2'd1, 8'h88); bus_write(2'd2, 8'h99);
        bus_write(2'd3, 8'hA0);
        bus_write(2'd3, 8'hC5);
        bus_write(2'd3, 8'h84);
        check_pins("R4 rejected words");

        // R2: writes while deselected, reads while deselected
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h9B;
        @(negedge clk);
        addr = 2'd0; wdata = 8'h11;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
        #1;
        check("R2 deselected read", rdata, 8'd0);
        rd_n = 1'b1;
        check_pins("R2 deselected write");

        // R10: output to input switch
        bus_write(2'd3, mode_word(4'b0000));
        bus_write(2'd0, 8'h5A); bus_write(2'd1, 8'hA5); bus_write(2'd2, 8'hF0);
        pa_in = 8'h21; pb_in = 8'h43; pc_in = 8'h65;
        check_pins("R10 before switch");
        bus_write(2'd3, mode_word(4'b1111));
        check_pins("R10 after switch");
        check_reads("R10 after switch");
        bus_write(2'd3, mode_word(4'b0101));
        bus_write(2'd2, 8'hC3);
        check_pins("R6 mixed C halves");
        check_reads("R8 mixed C halves");
        bus_read(2'd3, r);
        check("R9 control read", r, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule